// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block turns one high-level flash operation into the ordered list of bus cycles a raw NAND device expects. A client presents an operation code, a target chip, a block, page and column address and a beat count for one cycle. The sequencer then drives the cycle requests to a lower bus cycle engine that owns the pin timing. Each request is a command, address, write-data or read-data cycle. Between cycles the sequencer waits on the device ready/busy line and on two fixed delays.

Write data is taken byte by byte from a streaming input, which advances on a take strobe. Read data leaves on a byte output with a valid strobe. Reads that fetch a status byte go to a status port instead. Program and erase end with an automatic status read inside the same chip-enable window. A write-protect level is passed to the device pin.

Top module: `nand_op_seq`

## Requirements
- R1: After reset all chip enables are high, `busy`, `done`, `cyc_valid` and `rd_valid` are low, `status` is 0x00 and `nand_wp_n` is low.
- R2: An accepted operation does not drive any chip enable low until `nand_rb_n` has been sampled high. Then only the enable bit indexed by `op_cs` goes low, and it stays low for every cycle of the operation.
- R3: Reset (op_code 0) issues command 0xFF, waits for `nand_rb_n` high, then releases the chip enable.
- R4: ID read (op_code 1) issues command 0x90, one address cycle of 0x00, then exactly five read cycles, each byte delivered on `rd_data` with `rd_valid`.
- R5: Status read (op_code 2) issues command 0x70 and one read cycle whose byte is loaded into `status` and not presented on `rd_valid`.
- R6: Page read (op_code 3) issues 0x00, four address cycles, 0x30, waits for ready, and then waits TRR_CYC delay cycles. It then issues `op_beats` read cycles delivered on `rd_data`. The first read request appears no sooner than TRR_CYC+4 clocks after `nand_rb_n` returns high.
- R7: Page program (op_code 4) issues 0x80 and four address cycles. Then come `op_beats` write cycles carrying successive `wr_data` bytes, then 0x10, a wait for ready, command 0x70 and one read cycle loaded into `status`.
- R8: Block erase (op_code 5) issues 0x60 and two address cycles: {block[1:0],6'b0}, then block[9:2]. Then come 0xD0, a wait for ready, command 0x70 and one read cycle loaded into `status`.
- R9: With `op_beats` = 0, page read and page program omit their data cycles but keep every command and address cycle.
- R10: `done` is a one-cycle pulse exactly CHZ_CYC+1 clocks after the chip enables return high, and `busy` falls with it.
- R11: `busy` is high from the cycle after acceptance until the done pulse. Requests seen while busy are ignored, and so are op_code values 6 and 7.
- R12: `nand_wp_n` equals the inverse of `wp_on` one clock later, regardless of operations.
- R13: The four address bytes go out in this order: column[7:0], {4'b0, column[11:8]}, {block[1:0], page[5:0]}, block[9:2]. `cyc_type` encodes 0 command, 1 address, 2 write data, 3 read data. A request is held on `cyc_valid` until `cyc_done`, which also carries `cyc_rdata` for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request strobe |
| op_code | input | 3 | Operation select (0..5) |
| op_cs | input | CS_W | Target chip index |
| op_block | input | 10 | Block address |
| op_page | input | 6 | Page within block |
| op_col | input | 12 | Column (byte) address |
| op_beats | input | BEAT_W | Data bytes to read or write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished pulse |
| status | output | 8 | Last status byte read |
| wr_data | input | 8 | Current write byte |
| wr_take | output | 1 | Write byte consumed |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte strobe |
| wp_on | input | 1 | Write protect request |
| cyc_valid | output | 1 | Bus cycle request |
| cyc_type | output | 2 | Bus cycle kind |
| cyc_byte | output | 8 | Command, address or write byte |
| cyc_done | input | 1 | Bus cycle completed |
| cyc_rdata | input | 8 | Byte returned by a read cycle |
| nand_ce_n | output | NUM_CE | Active-low chip enables |
| nand_rb_n | input | 1 | Device ready (high) / busy (low) |
| nand_wp_n | output | 1 | Active-low write protect |

## Verification
A wrong step index shows at once on the cycle port. The next request carries the wrong kind or byte, or a command or address is missing, in the same operation. A wrong beat count adds or drops a data cycle just before the closing command. That closing command then shifts in the recorded list, so the whole sequence compares unequal. Enable or timer faults show as a chip enable going low while the device is busy, a request outside the enable window, or a done pulse some clocks early or late against the enable release. The bench measures each of these per operation.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   localparam int unsigned COL_W  = 12;
   localparam int unsigned PAGE_W = 6;
   localparam int unsigned BLK_W  = 10;
   localparam int unsigned ID_LEN = 5;

   localparam logic [7:0] C_RESET  = 8'hFF;
   localparam logic [7:0] C_ID     = 8'h90;
   localparam logic [7:0] C_STAT   = 8'h70;
   localparam logic [7:0] C_RD1    = 8'h00;
   localparam logic [7:0] C_RD2    = 8'h30;
   localparam logic [7:0] C_PG1    = 8'h80;
   localparam logic [7:0] C_PG2    = 8'h10;
   localparam logic [7:0] C_ER1    = 8'h60;
   localparam logic [7:0] C_ER2    = 8'hD0;

   typedef enum logic [2:0] {
      OP_RESET = 3'd0, OP_READID = 3'd1, OP_STATUS = 3'd2,
      OP_PGREAD = 3'd3, OP_PGPROG = 3'd4, OP_ERASE = 3'd5
   } op_e;

   typedef enum logic [1:0] {
      CY_CMD = 2'd0, CY_ADDR = 2'd1, CY_WR = 2'd2, CY_RD = 2'd3
   } cyc_e;

   typedef enum logic [2:0] {
      SK_CMD, SK_ADDR, SK_WDATA, SK_RDATA, SK_RSTAT, SK_WAITRB, SK_DELAY, SK_END
   } step_e;

   typedef struct packed {
      step_e      kind;
      logic [7:0] val;
   } step_t;

endpackage

// File: rtl/nand_seq_timer.sv
module nand_seq_timer #(
   parameter int unsigned MAX = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   generate
      if (MAX == 0) begin : g_none
         logic unused_in;
         assign unused_in = load ^ clk ^ rst_n;
         assign expired   = 1'b1;
      end else begin : g_cnt
         localparam int unsigned W = $clog2(MAX + 1);
         logic [W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (load)       cnt <= W'(MAX);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end

         assign expired = (cnt == '0);

         // R10: an idle timer never wraps back into a count
         p_timer_rest_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == '0 && !load) |=> (cnt == '0));
      end
   endgenerate
endmodule

// File: rtl/nand_seq_steps.sv
module nand_seq_steps
   import nand_seq_pkg::*;
(
   input  op_e               op,
   input  logic [3:0]        idx,
   input  logic [COL_W-1:0]  col,
   input  logic [PAGE_W-1:0] page,
   input  logic [BLK_W-1:0]  blk,
   output step_t             step
);
   function automatic step_t mk(step_e k, logic [7:0] v);
      step_t s;
      s.kind = k;
      s.val  = v;
      return s;
   endfunction

   logic [7:0] a_col_lo, a_col_hi, a_row_lo, a_row_hi, a_erase_lo;
   assign a_col_lo   = col[7:0];
   assign a_col_hi   = {4'b0000, col[11:8]};
   assign a_row_lo   = {blk[1:0], page};
   assign a_row_hi   = blk[9:2];
   assign a_erase_lo = {blk[1:0], 6'b000000};

   always_comb begin
      step = mk(SK_END, 8'h00);
      unique case (op)
         OP_RESET: case (idx)
            4'd0: step = mk(SK_CMD, C_RESET);
            4'd1: step = mk(SK_WAITRB, 8'h00);
            default: ;
         endcase
         OP_READID: case (idx)
            4'd0: step = mk(SK_CMD, C_ID);
            4'd1: step = mk(SK_ADDR, 8'h00);
            4'd2: step = mk(SK_RDATA, 8'h00);
            default: ;
         endcase
         OP_STATUS: case (idx)
            4'd0: step = mk(SK_CMD, C_STAT);
            4'd1: step = mk(SK_RSTAT, 8'h00);
            default: ;
         endcase
         OP_PGREAD: case (idx)
            4'd0: step = mk(SK_CMD, C_RD1);
            4'd1: step = mk(SK_ADDR, a_col_lo);
            4'd2: step = mk(SK_ADDR, a_col_hi);
            4'd3: step = mk(SK_ADDR, a_row_lo);
            4'd4: step = mk(SK_ADDR, a_row_hi);
            4'd5: step = mk(SK_CMD, C_RD2);
            4'd6: step = mk(SK_WAITRB, 8'h00);
            4'd7: step = mk(SK_DELAY, 8'h00);
            4'd8: step = mk(SK_RDATA, 8'h00);
            default: ;
         endcase
         OP_PGPROG: case (idx)
            4'd0: step = mk(SK_CMD, C_PG1);
            4'd1: step = mk(SK_ADDR, a_col_lo);
            4'd2: step = mk(SK_ADDR, a_col_hi);
            4'd3: step = mk(SK_ADDR, a_row_lo);
            4'd4: step = mk(SK_ADDR, a_row_hi);
            4'd5: step = mk(SK_WDATA, 8'h00);
            4'd6: step = mk(SK_CMD, C_PG2);
            4'd7: step = mk(SK_WAITRB, 8'h00);
            4'd8: step = mk(SK_CMD, C_STAT);
            4'd9: step = mk(SK_RSTAT, 8'h00);
            default: ;
         endcase
         OP_ERASE: case (idx)
            4'd0: step = mk(SK_CMD, C_ER1);
            4'd1: step = mk(SK_ADDR, a_erase_lo);
            4'd2: step = mk(SK_ADDR, a_row_hi);
            4'd3: step = mk(SK_CMD, C_ER2);
            4'd4: step = mk(SK_WAITRB, 8'h00);
            4'd5: step = mk(SK_CMD, C_STAT);
            4'd6: step = mk(SK_RSTAT, 8'h00);
            default: ;
         endcase
         default: ;
      endcase
   end
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
   import nand_seq_pkg::*;
#(
   parameter  int unsigned NUM_CE  = 2,
   parameter  int unsigned BEAT_W  = 16,
   parameter  int unsigned TRR_CYC = 3,
   parameter  int unsigned CHZ_CYC = 4,
   localparam int unsigned CS_W    = (NUM_CE > 1) ? $clog2(NUM_CE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [CS_W-1:0]   op_cs,
   input  logic [9:0]        op_block,
   input  logic [5:0]        op_page,
   input  logic [11:0]       op_col,
   input  logic [BEAT_W-1:0] op_beats,
   output logic              busy,
   output logic              done,
   output logic [7:0]        status,
   input  logic [7:0]        wr_data,
   output logic              wr_take,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   input  logic              wp_on,
   output logic              cyc_valid,
   output logic [1:0]        cyc_type,
   output logic [7:0]        cyc_byte,
   input  logic              cyc_done,
   input  logic [7:0]        cyc_rdata,
   output logic [NUM_CE-1:0] nand_ce_n,
   input  logic              nand_rb_n,
   output logic              nand_wp_n
);
   generate
      if (NUM_CE < 1 || NUM_CE > 16) begin : g_bad_ce
         $error("NUM_CE must be within 1..16");
      end
      if (BEAT_W < 3) begin : g_bad_beat
         $error("BEAT_W must hold the ID byte count");
      end
   endgenerate

   typedef enum logic [2:0] {Q_IDLE, Q_RDY, Q_STEP, Q_CYC, Q_WRB, Q_DLY, Q_CHZ} seq_q_e;

   seq_q_e              q;
   op_e                 op_q;
   logic [CS_W-1:0]     cs_q;
   logic [BLK_W-1:0]    blk_q;
   logic [PAGE_W-1:0]   pg_q;
   logic [COL_W-1:0]    col_q;
   logic [BEAT_W-1:0]   left_q;
   logic [3:0]          idx_q;
   cyc_e                ctype_q;
   logic [7:0]          cbyte_q;
   step_e               ckind_q;
   logic [NUM_CE-1:0]   ce_n_q;
   logic                busy_q, done_q, rd_valid_q, wp_n_q;
   logic [7:0]          status_q, rd_data_q;
   step_t               step;
   logic                trr_exp, chz_exp, accept;

   nand_seq_steps u_steps (
      .op(op_q), .idx(idx_q), .col(col_q), .page(pg_q), .blk(blk_q), .step(step)
   );

   nand_seq_timer #(.MAX(TRR_CYC)) u_trr (
      .clk(clk), .rst_n(rst_n),
      .load(q == Q_STEP && step.kind == SK_DELAY), .expired(trr_exp)
   );

   nand_seq_timer #(.MAX(CHZ_CYC)) u_chz (
      .clk(clk), .rst_n(rst_n),
      .load(q == Q_STEP && step.kind == SK_END), .expired(chz_exp)
   );

   assign accept = (q == Q_IDLE) && op_valid && (op_code <= 3'd5);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q          <= Q_IDLE;
         op_q       <= OP_RESET;
         cs_q       <= '0;
         blk_q      <= '0;
         pg_q       <= '0;
         col_q      <= '0;
         left_q     <= '0;
         idx_q      <= '0;
         ctype_q    <= CY_CMD;
         cbyte_q    <= '0;
         ckind_q    <= SK_END;
         ce_n_q     <= '1;
         busy_q     <= 1'b0;
         done_q     <= 1'b0;
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
         status_q   <= '0;
         wp_n_q     <= 1'b0;
      end else begin
         done_q     <= 1'b0;
         rd_valid_q <= 1'b0;
         wp_n_q     <= ~wp_on;
         unique case (q)
            Q_IDLE: if (accept) begin
               op_q   <= op_e'(op_code);
               cs_q   <= op_cs;
               blk_q  <= op_block;
               pg_q   <= op_page;
               col_q  <= op_col;
               left_q <= (op_e'(op_code) == OP_READID) ? BEAT_W'(ID_LEN) : op_beats;
               idx_q  <= '0;
               busy_q <= 1'b1;
               q      <= Q_RDY;
            end
            Q_RDY: if (nand_rb_n) begin
               for (int i = 0; i < NUM_CE; i++) ce_n_q[i] <= (CS_W'(i) != cs_q);
               q <= Q_STEP;
            end
            Q_STEP: begin
               ckind_q <= step.kind;
               cbyte_q <= step.val;
               unique case (step.kind)
                  SK_CMD:  begin ctype_q <= CY_CMD;  q <= Q_CYC; end
                  SK_ADDR: begin ctype_q <= CY_ADDR; q <= Q_CYC; end
                  SK_WDATA: begin
                     if (left_q == '0) idx_q <= idx_q + 4'd1;
                     else begin ctype_q <= CY_WR; q <= Q_CYC; end
                  end
                  SK_RDATA: begin
                     if (left_q == '0) idx_q <= idx_q + 4'd1;
                     else begin ctype_q <= CY_RD; q <= Q_CYC; end
                  end
                  SK_RSTAT:  begin ctype_q <= CY_RD; q <= Q_CYC; end
                  SK_WAITRB: q <= Q_WRB;
                  SK_DELAY:  q <= Q_DLY;
                  default: begin ce_n_q <= '1; q <= Q_CHZ; end
               endcase
            end
            Q_CYC: if (cyc_done) begin
               q <= Q_STEP;
               if (ckind_q == SK_RDATA) begin
                  rd_valid_q <= 1'b1;
                  rd_data_q  <= cyc_rdata;
               end
               if (ckind_q == SK_RSTAT) status_q <= cyc_rdata;
               if (ckind_q == SK_RDATA || ckind_q == SK_WDATA) begin
                  left_q <= left_q - 1'b1;
                  if (left_q == BEAT_W'(1)) idx_q <= idx_q + 4'd1;
               end else begin
                  idx_q <= idx_q + 4'd1;
               end
            end
            Q_WRB: if (nand_rb_n) begin
               idx_q <= idx_q + 4'd1;
               q     <= Q_STEP;
            end
            Q_DLY: if (trr_exp) begin
               idx_q <= idx_q + 4'd1;
               q     <= Q_STEP;
            end
            default: if (chz_exp) begin
               done_q <= 1'b1;
               busy_q <= 1'b0;
               q      <= Q_IDLE;
            end
         endcase
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign status    = status_q;
   assign rd_data   = rd_data_q;
   assign rd_valid  = rd_valid_q;
   assign nand_ce_n = ce_n_q;
   assign nand_wp_n = wp_n_q;
   assign cyc_valid = (q == Q_CYC);
   assign cyc_type  = ctype_q;
   assign cyc_byte  = (ctype_q == CY_WR) ? wr_data : cbyte_q;
   assign wr_take   = (q == Q_CYC) && cyc_done && (ctype_q == CY_WR);

   p_ce_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~nand_ce_n) <= 1);

   p_ce_waits_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((&$past(nand_ce_n)) && !(&nand_ce_n)) |-> $past(nand_rb_n));

   p_cyc_in_window_r13: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid |-> !(&nand_ce_n));

   p_idle_ce_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (&nand_ce_n));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_hold_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(op_q));

   p_rd_stream_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (op_q == OP_READID || op_q == OP_PGREAD));

   p_wp_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (nand_wp_n == !$past(wp_on)));

endmodule

// File: tb/tb_nand_op_seq.sv
module tb_nand_op_seq;
   localparam int TRR = 3;
   localparam int CHZ = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic op_valid = 1'b0;
   logic [2:0] op_code = '0;
   logic [0:0] op_cs = '0;
   logic [9:0] op_block = '0;
   logic [5:0] op_page = '0;
   logic [11:0] op_col = '0;
   logic [15:0] op_beats = '0;
   logic busy, done, wr_take, rd_valid, cyc_valid, nand_wp_n;
   logic [7:0] status, rd_data, cyc_byte;
   logic [7:0] wr_data = '0, cyc_rdata = '0;
   logic wp_on = 1'b0, cyc_done = 1'b0, nand_rb_n = 1'b1;
   logic [1:0] cyc_type, nand_ce_n;

   nand_op_seq #(.NUM_CE(2), .BEAT_W(16), .TRR_CYC(TRR), .CHZ_CYC(CHZ)) dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_cs(op_cs),
      .op_block(op_block), .op_page(op_page), .op_col(op_col), .op_beats(op_beats),
      .busy(busy), .done(done), .status(status), .wr_data(wr_data), .wr_take(wr_take),
      .rd_data(rd_data), .rd_valid(rd_valid), .wp_on(wp_on), .cyc_valid(cyc_valid),
      .cyc_type(cyc_type), .cyc_byte(cyc_byte), .cyc_done(cyc_done), .cyc_rdata(cyc_rdata),
      .nand_ce_n(nand_ce_n), .nand_rb_n(nand_rb_n), .nand_wp_n(nand_wp_n)
   );

   always #4 clk = ~clk;

   int nchk = 0, nerr = 0;
   int rt[0:127], rbv[0:127], rce[0:127], nrec = 0;
   int rdq[0:127], nrd = 0;
   int wbuf[0:63], widx = 0;
   int et[0:127], eb[0:127], ne = 0;
   int lat = 0, rb_hold = 0, cyc_cnt = 0;
   int ce_viol = 0, ndone = 0, ce_rel_t = -1, done_t = -1, rb_rise_t = -1, first_rd_gap = -1;
   logic [1:0] ce_prev = 2'b11;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // bus cycle engine and device model, acting at the falling edge
   initial forever begin
      @(negedge clk);
      if (ce_prev == 2'b11 && nand_ce_n != 2'b11 && !nand_rb_n) ce_viol++;
      if (ce_prev != 2'b11 && nand_ce_n == 2'b11) ce_rel_t = cyc_cnt;
      if (done) begin ndone++; done_t = cyc_cnt; end
      ce_prev = nand_ce_n;
      if (rd_valid && nrd < 128) begin rdq[nrd] = int'(rd_data); nrd++; end
      if (cyc_done) cyc_done = 1'b0;
      else if (cyc_valid) begin
         if (lat > 0) lat--;
         else begin
            if (cyc_type == 2'd3) cyc_rdata = 8'($urandom);
            if (nrec < 128) begin
               rt[nrec]  = int'(cyc_type);
               rbv[nrec] = (cyc_type == 2'd3) ? int'(cyc_rdata) : int'(cyc_byte);
               rce[nrec] = int'(nand_ce_n);
               nrec++;
            end
            if (cyc_type == 2'd3 && first_rd_gap < 0 && rb_rise_t >= 0)
               first_rd_gap = cyc_cnt - rb_rise_t;
            if (cyc_type == 2'd2) begin widx++; wr_data = 8'(wbuf[widx % 64]); end
            if (cyc_type == 2'd0 && (cyc_byte == 8'hFF || cyc_byte == 8'h30 ||
                                     cyc_byte == 8'h10 || cyc_byte == 8'hD0))
               rb_hold = 4 + int'($urandom % 6);
            cyc_done = 1'b1;
            lat = int'($urandom % 3);
         end
      end
      if (rb_hold > 0) begin nand_rb_n = 1'b0; rb_hold--; end
      else if (!nand_rb_n) begin nand_rb_n = 1'b1; rb_rise_t = cyc_cnt; end
      cyc_cnt++;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   task automatic push(input int t, input int b);
      et[ne] = t; eb[ne] = b; ne++;
   endtask

   function automatic string tag_of(input int op, input int beats);
      string s;
      case (op)
         0: s = "R3"; 1: s = "R4"; 2: s = "R5";
         3: s = "R6/R13"; 4: s = "R7/R13"; default: s = "R8";
      endcase
      if ((op == 3 || op == 4) && beats == 0) s = {s, "/R9"};
      return s;
   endfunction

   task automatic run_op(input int op, input int cs, input int blk, input int pg,
                         input int col, input int beats, input bit pre_busy, input bit spam);
      int t;
      bit ok;
      int bad;
      int mask;
      int nr_exp;
      string tg;
      tg = tag_of(op, beats);
      @(negedge clk); #1;
      for (int i = 0; i < 64; i++) wbuf[i] = int'($urandom % 256);
      widx = 0; wr_data = 8'(wbuf[0]);
      nrec = 0; nrd = 0; ndone = 0; ce_viol = 0;
      ce_rel_t = -1; done_t = -1; rb_rise_t = -1; first_rd_gap = -1;
      if (pre_busy) rb_hold = 12;
      op_valid = 1'b1; op_code = 3'(op); op_cs = 1'(cs);
      op_block = 10'(blk); op_page = 6'(pg); op_col = 12'(col); op_beats = 16'(beats);
      @(negedge clk); #1;
      op_valid = 1'b0;
      if (spam) begin
         repeat (3) @(negedge clk);
         #1;
         op_valid = 1'b1; op_code = (op == 2) ? 3'd5 : 3'd2; op_cs = ~op_cs;
         repeat (2) @(negedge clk);
         #1;
         op_valid = 1'b0;
      end
      t = 0;
      while (ndone == 0 && t < 4000) begin @(negedge clk); #1; t++; end
      chk(ndone != 0, tg, "operation completes", ndone, 1);
      repeat (3) @(negedge clk);
      #1;
      chk(ndone == 1 && busy == 1'b0 && nand_ce_n == 2'b11, "R11",
          "single done, idle after", ndone * 16 + int'(busy), 16);
      chk(done_t - ce_rel_t == CHZ + 1, "R10", "done gap after enable release",
          done_t - ce_rel_t, CHZ + 1);
      chk(ce_viol == 0, "R2", "enable asserted while device busy", ce_viol, 0);

      ne = 0;
      case (op)
         0: push(0, 'hFF);
         1: begin push(0, 'h90); push(1, 0); for (int k = 0; k < 5; k++) push(3, -1); end
         2: begin push(0, 'h70); push(3, -1); end
         3, 4: begin
            push(0, (op == 3) ? 'h00 : 'h80);
            push(1, col & 'hFF); push(1, (col >> 8) & 'hF);
            push(1, ((blk & 3) << 6) | (pg & 'h3F)); push(1, (blk >> 2) & 'hFF);
            if (op == 3) begin
               push(0, 'h30);
               for (int k = 0; k < beats; k++) push(3, -1);
            end else begin
               for (int k = 0; k < beats; k++) push(2, wbuf[k]);
               push(0, 'h10); push(0, 'h70); push(3, -1);
            end
         end
         default: begin
            push(0, 'h60); push(1, (blk & 3) << 6); push(1, (blk >> 2) & 'hFF);
            push(0, 'hD0); push(0, 'h70); push(3, -1);
         end
      endcase
      mask = (cs == 0) ? 2 : 1;
      ok = (ne == nrec);
      bad = -1;
      for (int i = 0; i < ne && i < nrec; i++)
         if (rt[i] != et[i] || (eb[i] >= 0 && rbv[i] != eb[i]) || rce[i] != mask) begin
            if (bad < 0) bad = i;
            ok = 1'b0;
         end
      chk(ok, tg, (bad >= 0) ? $sformatf("cycle %0d type/byte", bad) : "cycle count",
          (bad >= 0) ? rt[bad] * 256 + rbv[bad] : nrec,
          (bad >= 0) ? et[bad] * 256 + eb[bad] : ne);

      if (op == 1 || op == 3) begin
         nr_exp = (op == 1) ? 5 : beats;
         ok = (nrd == nr_exp);
         for (int i = 0, j = 0; i < nrec; i++)
            if (rt[i] == 3) begin
               if (j >= nrd || rdq[j] != rbv[i]) ok = 1'b0;
               j++;
            end
         chk(ok, (op == 1) ? "R4" : "R6", "read bytes delivered", nrd, nr_exp);
      end else begin
         chk(nrd == 0, "R5", "no read strobe outside data reads", nrd, 0);
      end
      if (op == 2 || op == 4 || op == 5)
         chk(nrec > 0 && int'(status) == rbv[nrec - 1], tg, "status byte",
             int'(status), (nrec > 0) ? rbv[nrec - 1] : -1);
      if (op == 3 && beats > 0)
         chk(first_rd_gap >= TRR + 4, "R6", "ready-to-read delay", first_rd_gap, TRR + 4);
   endtask

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      #1;
      chk(nand_ce_n == 2'b11 && !busy && !done && !cyc_valid && !rd_valid &&
          status == 8'h00 && nand_wp_n == 1'b0, "R1", "reset state",
          {nand_ce_n, busy, done, cyc_valid, rd_valid}, 6'b110000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk(nand_wp_n == 1'b1, "R12", "write protect released", int'(nand_wp_n), 1);
      wp_on = 1'b1;
      @(negedge clk); #1;
      chk(nand_wp_n == 1'b0, "R12", "write protect asserted", int'(nand_wp_n), 0);
      wp_on = 1'b0;

      // directed corner cases
      run_op(0, 0, 0, 0, 0, 0, 1'b1, 1'b0);
      run_op(1, 1, 0, 0, 0, 0, 1'b0, 1'b0);
      run_op(2, 0, 0, 0, 0, 0, 1'b1, 1'b0);
      run_op(3, 1, 1023, 63, 4095, 7, 1'b0, 1'b0);
      run_op(3, 0, 5, 2, 300, 0, 1'b0, 1'b0);
      run_op(4, 1, 514, 33, 2049, 9, 1'b0, 1'b1);
      run_op(4, 0, 3, 1, 17, 0, 1'b0, 1'b0);
      run_op(5, 1, 1023, 0, 0, 0, 1'b1, 1'b1);

      // R11: reserved opcodes are ignored
      @(negedge clk); #1;
      nrec = 0;
      op_valid = 1'b1; op_code = 3'd6;
      @(negedge clk); #1;
      op_code = 3'd7;
      @(negedge clk); #1;
      op_valid = 1'b0;
      repeat (6) @(negedge clk);
      #1;
      chk(!busy && nrec == 0 && nand_ce_n == 2'b11, "R11", "reserved opcode ignored",
          nrec + int'(busy), 0);

      // R12: protect level follows during an operation
      wp_on = 1'b1;
      run_op(2, 1, 0, 0, 0, 0, 1'b0, 1'b0);
      chk(nand_wp_n == 1'b0, "R12", "protect held across operation", int'(nand_wp_n), 0);
      wp_on = 1'b0;

      for (int n = 0; n < 30; n++) begin
         int rop;
         rop = int'($urandom % 6);
         run_op(rop, int'($urandom % 2), int'($urandom % 1024), int'($urandom % 64),
                int'($urandom % 4096), int'($urandom % 21), 1'(($urandom % 4) == 0), 1'b0);
      end

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule